// File: doc/BRIEF.md
# Test access port controller with instruction decode

This block is the serial test port of a chip. Four pins (test clock, mode select, serial data in and an active-low asynchronous reset) drive the sixteen-state controller, and one serial output returns the shifted data. Inside are the controller, an 8-bit instruction register and a 1-bit bypass register. The decoded instruction picks the data path that a data scan walks through: either an external boundary chain or the bypass bit. The instruction also decides whether all functional outputs of the chip are forced to high impedance.

The boundary cells themselves live outside. This block hands them a select, capture, shift and update strobes, the serial input bit, and an input-pin sampling strobe. It takes back their serial output. A build parameter moves the input-pin sampling from the rising edge in Capture-DR to the falling edge of the first Shift-DR state, half a clock later. Another parameter gives the five revision bits that the instruction register reports during Capture-IR.

All state advances on the rising test clock. The serial output and its valid flag change on the falling edge.

Top module: `tap_ctrl`

## Requirements
- R1: While trst_n is low, the controller is in Test-Logic-Reset and the instruction is BYPASS (8'hFF), so bnd_sel and out_hiz are 0. Each rising edge spent in Test-Logic-Reset reloads BYPASS.
- R2: Five consecutive rising edges with tms high bring the controller to Test-Logic-Reset from any state. One further rising edge later, bnd_sel is 0.
- R3: In Capture-IR the instruction shift register loads {1'b0, REV_CODE[4:0], 2'b01}. Shift-IR then presents it on tdo least significant bit first, while tdi enters at the most significant bit.
- R4: The instruction takes effect on the rising edge that leaves Update-IR. Opcodes 8'h00 (external test) and 8'h02 (sample) set bnd_sel to 1, and a data scan then returns bnd_so on tdo.
- R5: Every other opcode, including 8'hFF, 8'h03 and 8'h20 to 8'h29, selects the bypass bit. The bypass bit loads 0 in Capture-DR, so a data scan returns 0 followed by tdi delayed by one clock.
- R6: Opcode 8'h06 sets out_hiz to 1 and selects the bypass bit. Any other opcode clears out_hiz.
- R7: tdo_en is 1 only while the controller is in Shift-IR or Shift-DR. tdo and tdo_en update on the falling clock edge. tdo is 0 whenever tdo_en is 0.
- R8: bnd_capture, bnd_shift and bnd_update are high in Capture-DR, Shift-DR and Update-DR respectively, and only while bnd_sel is 1. bnd_si always equals tdi.
- R9: With LATE_SAMPLE=0, pin_sample is high in Capture-DR, and the cells sample on the rising edge. With LATE_SAMPLE=1, pin_sample is high only in the first Shift-DR state after Capture-DR, and the cells sample on the falling edge. pin_sample is never high while bypass is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdo_en | output | 1 | High while tdo carries shifted data |
| bnd_sel | output | 1 | Boundary chain selected for data scans |
| bnd_si | output | 1 | Serial input to the boundary chain |
| bnd_so | input | 1 | Serial output from the boundary chain |
| bnd_capture | output | 1 | Boundary chain capture strobe |
| bnd_shift | output | 1 | Boundary chain shift strobe |
| bnd_update | output | 1 | Boundary chain update strobe |
| pin_sample | output | 1 | Input-pin sampling strobe for the boundary cells |
| out_hiz | output | 1 | Force all functional outputs to high impedance |

## Verification
The bench builds two copies side by side on the same pins. One uses LATE_SAMPLE=0 with revision code 5'b01000, so its instruction capture reads 8'h21. The other uses LATE_SAMPLE=1 with revision code 5'b00100, so its capture reads 8'h11. Two different capture words expose any fixed or misplaced revision bits. Running both sampling variants on the same scan shows pin_sample moving from Capture-DR into the first Shift-DR state. A small bench-side boundary chain, driven by the strobes of the first copy, checks that the strobes and the serial path line up bit for bit.

// File: rtl/tap_pkg.sv
package tap_pkg;
    localparam int IR_W  = 8;
    localparam int REV_W = IR_W - 3;

    localparam logic [IR_W-1:0] OP_EXTEST = 8'h00;
    localparam logic [IR_W-1:0] OP_SAMPLE = 8'h02;
    localparam logic [IR_W-1:0] OP_HIGHZ  = 8'h06;
    localparam logic [IR_W-1:0] OP_BYPASS = 8'hFF;

    typedef enum logic [3:0] {
        S_RESET   = 4'd0,
        S_IDLE    = 4'd1,
        S_DR_SEL  = 4'd2,
        S_DR_CAP  = 4'd3,
        S_DR_SH   = 4'd4,
        S_DR_EX1  = 4'd5,
        S_DR_PAU  = 4'd6,
        S_DR_EX2  = 4'd7,
        S_DR_UPD  = 4'd8,
        S_IR_SEL  = 4'd9,
        S_IR_CAP  = 4'd10,
        S_IR_SH   = 4'd11,
        S_IR_EX1  = 4'd12,
        S_IR_PAU  = 4'd13,
        S_IR_EX2  = 4'd14,
        S_IR_UPD  = 4'd15
    } tap_st_e;

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] op;
    } ir_regs_t;

    typedef struct packed {
        logic byp;
        logic first_sh;
    } dr_regs_t;

    typedef struct packed {
        logic tdo;
        logic en;
    } out_regs_t;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic    tck,
    input  logic    trst_n,
    input  logic    tms,
    output tap_st_e st
);
    tap_st_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_RESET:  st_d = tms ? S_RESET  : S_IDLE;
            S_IDLE:   st_d = tms ? S_DR_SEL : S_IDLE;
            S_DR_SEL: st_d = tms ? S_IR_SEL : S_DR_CAP;
            S_DR_CAP: st_d = tms ? S_DR_EX1 : S_DR_SH;
            S_DR_SH:  st_d = tms ? S_DR_EX1 : S_DR_SH;
            S_DR_EX1: st_d = tms ? S_DR_UPD : S_DR_PAU;
            S_DR_PAU: st_d = tms ? S_DR_EX2 : S_DR_PAU;
            S_DR_EX2: st_d = tms ? S_DR_UPD : S_DR_SH;
            S_DR_UPD: st_d = tms ? S_DR_SEL : S_IDLE;
            S_IR_SEL: st_d = tms ? S_RESET  : S_IR_CAP;
            S_IR_CAP: st_d = tms ? S_IR_EX1 : S_IR_SH;
            S_IR_SH:  st_d = tms ? S_IR_EX1 : S_IR_SH;
            S_IR_EX1: st_d = tms ? S_IR_UPD : S_IR_PAU;
            S_IR_PAU: st_d = tms ? S_IR_EX2 : S_IR_PAU;
            S_IR_EX2: st_d = tms ? S_IR_UPD : S_IR_SH;
            S_IR_UPD: st_d = tms ? S_DR_SEL : S_IDLE;
            default:  st_d = S_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= S_RESET;
        else         st_q <= st_d;
    end

    assign st = st_q;

    // checker: run of consecutive tms-high edges, saturating at five
    logic [2:0] hi_run_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)              hi_run_q <= 3'd0;
        else if (!tms)            hi_run_q <= 3'd0;
        else if (hi_run_q != 3'd5) hi_run_q <= hi_run_q + 3'd1;
    end

    // R2
    five_high_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (hi_run_q == 3'd5) |-> (st_q == S_RESET))
        else $error("five tms-high edges did not reach reset state");
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
#(
    parameter logic [REV_W-1:0] REV_CODE = 5'b01000
) (
    input  logic            tck,
    input  logic            trst_n,
    input  tap_st_e         st,
    input  logic            tdi,
    output logic [IR_W-1:0] opcode,
    output logic            ir_so
);
    localparam logic [IR_W-1:0] CAP_PAT = {1'b0, REV_CODE, 2'b01};

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (st)
            S_RESET:  r_d.op = OP_BYPASS;
            S_IR_CAP: r_d.sh = CAP_PAT;
            S_IR_SH:  r_d.sh = {tdi, r_q.sh[IR_W-1:1]};
            S_IR_UPD: r_d.op = r_q.sh;
            default:  ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            r_q.sh <= '0;
            r_q.op <= OP_BYPASS;
        end else begin
            r_q <= r_d;
        end
    end

    assign opcode = r_q.op;
    assign ir_so  = r_q.sh[0];

    // R3
    ir_capture_pattern_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (st == S_IR_CAP) |=> (r_q.sh == CAP_PAT))
        else $error("instruction capture pattern wrong");

    // R1
    reset_state_bypass_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (st == S_RESET) |=> (r_q.op == OP_BYPASS))
        else $error("instruction not bypass after reset state");
endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter bit LATE_SAMPLE = 1'b0
) (
    input  logic            tck,
    input  logic            trst_n,
    input  tap_st_e         st,
    input  logic            tdi,
    input  logic [IR_W-1:0] opcode,
    input  logic            ir_so,
    input  logic            bnd_so,
    output logic            bnd_sel,
    output logic            out_hiz,
    output logic            bnd_capture,
    output logic            bnd_shift,
    output logic            bnd_update,
    output logic            pin_sample,
    output logic            tdo,
    output logic            tdo_en
);
    // instruction decode: only the two boundary opcodes reach the chain
    always_comb begin
        unique case (opcode)
            OP_EXTEST, OP_SAMPLE: bnd_sel = 1'b1;
            default:              bnd_sel = 1'b0;
        endcase
    end
    assign out_hiz = (opcode == OP_HIGHZ);

    assign bnd_capture = bnd_sel && (st == S_DR_CAP);
    assign bnd_shift   = bnd_sel && (st == S_DR_SH);
    assign bnd_update  = bnd_sel && (st == S_DR_UPD);

    // rising-edge state: bypass bit and first-shift marker
    dr_regs_t p_d, p_q;

    always_comb begin
        p_d          = p_q;
        p_d.first_sh = (st == S_DR_CAP);
        if (st == S_DR_CAP)     p_d.byp = 1'b0;
        else if (st == S_DR_SH) p_d.byp = tdi;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) p_q <= '0;
        else         p_q <= p_d;
    end

    generate
        if (LATE_SAMPLE) begin : g_late
            assign pin_sample = bnd_sel && (st == S_DR_SH) && p_q.first_sh;
        end else begin : g_ontime
            assign pin_sample = bnd_capture;
        end
    endgenerate

    // falling-edge output stage
    out_regs_t n_d, n_q;
    logic      dr_so;

    assign dr_so = bnd_sel ? bnd_so : p_q.byp;

    always_comb begin
        n_d.en  = (st == S_IR_SH) || (st == S_DR_SH);
        n_d.tdo = 1'b0;
        if (st == S_IR_SH)      n_d.tdo = ir_so;
        else if (st == S_DR_SH) n_d.tdo = dr_so;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) n_q <= '0;
        else         n_q <= n_d;
    end

    assign tdo    = n_q.tdo;
    assign tdo_en = n_q.en;

    // R5
    bypass_captures_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (st == S_DR_CAP) |=> (p_q.byp == 1'b0))
        else $error("bypass bit did not capture zero");

    // R6
    hiz_uses_bypass_chk: assert property (@(posedge tck) disable iff (!trst_n)
        out_hiz |-> !bnd_sel)
        else $error("high impedance with boundary selected");

    // R7
    tdo_valid_in_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> ((st == S_IR_SH) || (st == S_DR_SH)))
        else $error("tdo enabled outside shift states");

    // R8
    strobes_exclusive_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({bnd_capture, bnd_shift, bnd_update}))
        else $error("boundary strobes overlap");

    // R9
    sample_needs_boundary_chk: assert property (@(posedge tck) disable iff (!trst_n)
        pin_sample |-> (bnd_sel && ((st == S_DR_CAP) || (st == S_DR_SH))))
        else $error("pin sample strobe outside boundary capture window");
endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
    import tap_pkg::*;
#(
    parameter logic [REV_W-1:0] REV_CODE    = 5'b01000,
    parameter bit               LATE_SAMPLE = 1'b0
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    output logic bnd_sel,
    output logic bnd_si,
    input  logic bnd_so,
    output logic bnd_capture,
    output logic bnd_shift,
    output logic bnd_update,
    output logic pin_sample,
    output logic out_hiz
);
    tap_st_e         st;
    logic [IR_W-1:0] opcode;
    logic            ir_so;

    tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .st     (st)
    );

    tap_ir #(.REV_CODE(REV_CODE)) u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .st     (st),
        .tdi    (tdi),
        .opcode (opcode),
        .ir_so  (ir_so)
    );

    tap_dr #(.LATE_SAMPLE(LATE_SAMPLE)) u_dr (
        .tck         (tck),
        .trst_n      (trst_n),
        .st          (st),
        .tdi         (tdi),
        .opcode      (opcode),
        .ir_so       (ir_so),
        .bnd_so      (bnd_so),
        .bnd_sel     (bnd_sel),
        .out_hiz     (out_hiz),
        .bnd_capture (bnd_capture),
        .bnd_shift   (bnd_shift),
        .bnd_update  (bnd_update),
        .pin_sample  (pin_sample),
        .tdo         (tdo),
        .tdo_en      (tdo_en)
    );

    assign bnd_si = tdi;

    // R7
    tdo_quiet_when_off_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_en |-> (tdo == 1'b0))
        else $error("tdo not zero while disabled");
endmodule

// File: tb/sim_tap_ctrl.sv
module sim_tap_ctrl;
    localparam int CLK_P = 100;
    localparam logic [3:0] CHAIN_PAT = 4'b1010;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo0, en0, sel0, si0, cap0, sh0, upd0, smp0, hiz0;
    logic tdo1, en1, sel1, si1, cap1, sh1, upd1, smp1, hiz1;
    logic [3:0] chain;

    int total = 0, bad = 0;
    int n_cap, n_sh, n_upd, n_smp0, n_smp0_ok, n_smp1, n_smp1_ok;
    logic prev_cap1;

    always #(CLK_P/2) tck = ~tck;

    tap_ctrl #(.REV_CODE(5'b01000), .LATE_SAMPLE(1'b0)) u0 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo0), .tdo_en(en0),
        .bnd_sel(sel0), .bnd_si(si0), .bnd_so(chain[0]), .bnd_capture(cap0),
        .bnd_shift(sh0), .bnd_update(upd0), .pin_sample(smp0), .out_hiz(hiz0));

    tap_ctrl #(.REV_CODE(5'b00100), .LATE_SAMPLE(1'b1)) u1 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo1), .tdo_en(en1),
        .bnd_sel(sel1), .bnd_si(si1), .bnd_so(chain[0]), .bnd_capture(cap1),
        .bnd_shift(sh1), .bnd_update(upd1), .pin_sample(smp1), .out_hiz(hiz1));

    // bench model of the external boundary chain
    always @(posedge tck) begin
        if (cap0)     chain <= CHAIN_PAT;
        else if (sh0) chain <= {si0, chain[3:1]};
    end

    // strobe counters, read in the middle of each cycle
    always @(negedge tck) begin
        if (cap0) n_cap++;
        if (sh0)  n_sh++;
        if (upd0) n_upd++;
        if (smp0) n_smp0++;
        if (smp0 && cap0) n_smp0_ok++;
        if (smp1) n_smp1++;
        if (smp1 && sh1 && prev_cap1) n_smp1_ok++;
        prev_cap1 = cap1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_cap = 0; n_sh = 0; n_upd = 0;
        n_smp0 = 0; n_smp0_ok = 0; n_smp1 = 0; n_smp1_ok = 0;
    endtask

    task automatic step(input logic m, input logic di,
                        output logic o0, output logic o1, output logic e0);
        @(negedge tck);
        #1;
        tms = m;
        tdi = di;
        #(CLK_P/4);
        o0 = tdo0;
        o1 = tdo1;
        e0 = en0;
        @(posedge tck);
        #1;
    endtask

    task automatic ir_scan(input logic [7:0] op, output logic [7:0] c0,
                           output logic [7:0] c1, output logic [7:0] ens);
        logic a, b, e;
        step(1, 0, a, b, e);
        step(1, 0, a, b, e);
        step(0, 0, a, b, e);
        step(0, 0, a, b, e);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, op[i], a, b, e);
            c0[i] = a; c1[i] = b; ens[i] = e;
        end
        step(1, 0, a, b, e);
        step(0, 0, a, b, e);
    endtask

    task automatic load_op(input logic [7:0] op);
        logic [7:0] c0, c1, ens;
        ir_scan(op, c0, c1, ens);
    endtask

    task automatic dr_scan(input int n, input logic [15:0] din, output logic [15:0] dout);
        logic a, b, e;
        dout = '0;
        clear_counts();
        step(1, 0, a, b, e);
        step(0, 0, a, b, e);
        step(0, 0, a, b, e);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], a, b, e);
            dout[i] = a;
        end
        step(1, 0, a, b, e);
        step(0, 0, a, b, e);
    endtask

    task automatic t_reset();
        logic a, b, e;
        trst_n = 1'b0;
        #(CLK_P * 2);
        check("R1 sel in reset", sel0, 1'b0);
        check("R1 hiz in reset", hiz0, 1'b0);
        check("R7 tdo_en in reset", en0, 1'b0);
        check("R7 tdo zero in reset", tdo0, 1'b0);
        trst_n = 1'b1;
        step(0, 0, a, b, e);
    endtask

    task automatic t_ir_capture();
        logic [7:0] c0, c1, ens;
        ir_scan(8'hFF, c0, c1, ens);
        check("R3 capture u0", c0, 8'h21);
        check("R3 capture u1", c1, 8'h11);
        check("R7 tdo_en during shift", ens, 8'hFF);
    endtask

    task automatic t_boundary(input logic [7:0] op);
        logic [15:0] dout;
        load_op(op);
        check("R4 bnd_sel", sel0, 1'b1);
        check("R6 hiz clear", hiz0, 1'b0);
        dr_scan(8, 16'h00C5, dout);
        check("R4 boundary data", dout[7:0], {4'h5, 4'b1010});
        check("R8 capture count", n_cap, 1);
        check("R8 shift count", n_sh, 8);
        check("R8 update count", n_upd, 1);
        check("R9 on-time sample count", n_smp0, 1);
        check("R9 on-time sample in capture", n_smp0_ok, 1);
        check("R9 late sample count", n_smp1, 1);
        check("R9 late sample in first shift", n_smp1_ok, 1);
    endtask

    task automatic t_bypass(input logic [7:0] op);
        logic [15:0] dout;
        load_op(op);
        check("R5 bnd_sel low", sel0, 1'b0);
        dr_scan(6, 16'h002D, dout);
        check("R5 bypass data", dout[5:0], {5'b01101, 1'b0});
        check("R8 no strobes in bypass", n_cap + n_sh + n_upd, 0);
        check("R9 no sample in bypass", n_smp0 + n_smp1, 0);
    endtask

    task automatic t_highz();
        logic [15:0] dout;
        load_op(8'h06);
        check("R6 hiz set", hiz0, 1'b1);
        check("R6 bypass selected", sel0, 1'b0);
        dr_scan(4, 16'h0007, dout);
        check("R6 bypass path in highz", dout[3:0], 4'b1110);
        load_op(8'h02);
        check("R6 hiz cleared", hiz0, 1'b0);
    endtask

    task automatic t_five_ones();
        logic a, b, e;
        load_op(8'h00);
        step(1, 0, a, b, e);
        step(0, 0, a, b, e);
        step(0, 0, a, b, e);
        for (int i = 0; i < 5; i++) step(1, 0, a, b, e);
        step(0, 0, a, b, e);
        check("R2 bypass after five ones", sel0, 1'b0);
        check("R7 tdo_en off after reset", e, 1'b0);
        load_op(8'h02);
        step(1, 0, a, b, e);
        step(1, 0, a, b, e);
        step(0, 0, a, b, e);
        step(0, 0, a, b, e);
        for (int i = 0; i < 5; i++) step(1, 0, a, b, e);
        step(0, 0, a, b, e);
        check("R2 from shift-ir", sel0, 1'b0);
    endtask

    task automatic t_async_reset();
        logic a, b, e;
        load_op(8'h00);
        step(1, 0, a, b, e);
        step(0, 0, a, b, e);
        @(negedge tck);
        #(CLK_P/8);
        trst_n = 1'b0;
        #(CLK_P/8);
        check("R1 async reset sel", sel0, 1'b0);
        check("R1 async reset strobe", cap0, 1'b0);
        #(CLK_P);
        trst_n = 1'b1;
        step(0, 0, a, b, e);
    endtask

    initial begin
        clear_counts();
        prev_cap1 = 1'b0;
        chain = 4'h0;
        t_reset();
        t_ir_capture();
        t_boundary(8'h00);
        t_boundary(8'h02);
        t_bypass(8'hFF);
        t_bypass(8'h03);
        t_bypass(8'h20);
        t_bypass(8'h29);
        t_bypass(8'h55);
        t_highz();
        t_five_ones();
        t_async_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule